// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller built from a parameterised number of banks. Each bank serves up to 32 pins and holds its own configuration words. Those words set each pin's direction, its output value and open-drain behaviour, the kind of input activity that counts as an interrupt event, and whether that event reaches the interrupt line. A bank can be declared with width 0. It then keeps its slot in the address map but has no pins.

Software uses a single-cycle 32-bit write port and a combinational read port. Input pads pass through a two-stage synchroniser before edge and level detection. A per-pin sticky status bit records each detected event, and software clears it by writing a one to it. Every bank contributes the AND of its status and mask words to one shared interrupt output, so a handler reads the status words to find which pins are pending. Each pin's trigger comes from three bits: level select, polarity and both-edges. This covers rising edge, falling edge, both edges, high level and low level.

Top module: `gpio_multibank`

## Requirements
- R1: After reset every configuration word and every status word reads 0, except the direction word, which reads 1 on every implemented pin (all pins are inputs). `pad_oe` and `irq` are 0.
- R2: Bank b sits at byte offset 32*b. Its word offsets are 0x00 open-drain enable, 0x04 data, 0x08 direction, 0x0C polarity, 0x10 both-edges, 0x14 mask, 0x18 level select and 0x1C status. A write stores its data and a read of the same word returns it.
- R3: A direction bit of 0 makes the pin an output and a 1 makes it an input. For an output pin, `pad_oe` is 1 and `pad_out` follows the data bit. A data-word read returns the synchronised pad for input pins and the output latch for output pins.
- R4: When an output pin's open-drain bit is 1, `pad_out` is 0 and `pad_oe` is the inverse of the data bit.
- R5: With level select 0 and both-edges 0, polarity 1 gives a rising-edge trigger and polarity 0 gives a falling-edge trigger. The status bit is 1 three clock edges after the pad changes.
- R6: With level select 0 and both-edges 1, both edges set status and the polarity bit has no effect.
- R7: With level select 1, polarity 1 detects a high level and polarity 0 a low level. Writing one to clear the status bit leaves it at 1 while the level is still present.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Status bits fall only after a status write.
- R9: Status bits latch events even when masked. `irq` is the OR, over all banks, of status AND mask. Unmasking a pending bit raises `irq` right after that write.
- R10: Bits at or above a bank's width read 0, ignore writes and never record events. A width-0 bank reads 0 in every word.
- R11: An address whose bank index is not below the bank count reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | NUM_BANKS*32 | Pad input levels, bank b at bits [32b+31:32b] |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds three banks of widths 8, 0 and 32 with an 8-bit address. That setting reaches partial-width masking on writes, reads and event capture (bank 0). It also reaches a hole in the map that must stay silent (bank 1), a full-width bank for the trigger modes (bank 2), and an address past the last bank. Having more than one bank lets the bench check that an event pending in one bank drives the shared interrupt after masks in another bank have been cleared.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  localparam int BANK_PINS   = 32;
  localparam int WIDTH_FIELD = 6;
  localparam int NUM_WORDS   = 8;

  // Word order inside a bank; software decodes these offsets.
  typedef enum logic [2:0] {
    RI_ODRAIN = 3'd0,
    RI_DATA   = 3'd1,
    RI_DIR    = 3'd2,
    RI_POL    = 3'd3,
    RI_BOTH   = 3'd4,
    RI_MASK   = 3'd5,
    RI_LEVEL  = 3'd6,
    RI_STAT   = 3'd7
  } reg_idx_e;

  function automatic logic [BANK_PINS-1:0] width_mask(input int w);
    if (w >= BANK_PINS) return '1;
    return (BANK_PINS'(1) << w) - BANK_PINS'(1);
  endfunction
endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
  import gpio_mb_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           idx,
  input  logic [BANK_PINS-1:0] wdata,
  output logic [BANK_PINS-1:0] rdata,
  input  logic [BANK_PINS-1:0] pad_in,
  output logic [BANK_PINS-1:0] pad_out,
  output logic [BANK_PINS-1:0] pad_oe,
  output logic                 irq,
  output logic [BANK_PINS-1:0] stat_o,
  output logic [BANK_PINS-1:0] mask_o,
  output logic [BANK_PINS-1:0] dir_o,
  output logic [BANK_PINS-1:0] od_o
);
  localparam logic [BANK_PINS-1:0] VALID = width_mask(WIDTH);
  localparam int NUM_CFG = NUM_WORDS - 1;

  logic [BANK_PINS-1:0] cfg [NUM_CFG];

  // Configuration words 0..6, one register each.
  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    localparam logic [BANK_PINS-1:0] RST_VAL = (k == int'(RI_DIR)) ? VALID : '0;
    logic                 we;
    logic [BANK_PINS-1:0] q, d;

    assign we = wr_en && (idx == 3'(k));

    always_comb begin
      d = q;
      if (we) d = wdata & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end

    assign cfg[k] = q;
  end

  logic [BANK_PINS-1:0] od, dat, dir, pol, both, msk, lvl;
  assign od   = cfg[RI_ODRAIN];
  assign dat  = cfg[RI_DATA];
  assign dir  = cfg[RI_DIR];
  assign pol  = cfg[RI_POL];
  assign both = cfg[RI_BOTH];
  assign msk  = cfg[RI_MASK];
  assign lvl  = cfg[RI_LEVEL];

  // Input path: synchroniser then one history stage.
  logic [BANK_PINS-1:0] syn, prev_q;

  gpio_mb_sync #(.W(BANK_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= syn;
  end

  logic [BANK_PINS-1:0] rise, fall, edge_ev, lvl_ev, ev;
  always_comb begin
    rise    = syn & ~prev_q;
    fall    = ~syn & prev_q;
    edge_ev = (both & (rise | fall))
            | (~both & pol & rise)
            | (~both & ~pol & fall);
    lvl_ev  = (pol & syn) | (~pol & ~syn);
    ev      = ((lvl & lvl_ev) | (~lvl & edge_ev)) & VALID;
  end

  // Sticky status, write-one-to-clear, new events win over a clear.
  logic [BANK_PINS-1:0] stat_q, stat_d, clr;
  always_comb begin
    clr    = (wr_en && idx == RI_STAT) ? wdata : '0;
    stat_d = ((stat_q & ~clr) | ev) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // Read mux.
  always_comb begin
    unique case (reg_idx_e'(idx))
      RI_DATA: rdata = ((dir & syn) | (~dir & dat)) & VALID;
      RI_STAT: rdata = stat_q;
      default: rdata = cfg[idx];
    endcase
  end

  assign pad_out = dat & ~od & VALID;
  assign pad_oe  = ~dir & ~(od & dat) & VALID;
  assign irq     = |(stat_q & msk);

  assign stat_o = stat_q;
  assign mask_o = msk;
  assign dir_o  = dir;
  assign od_o   = od;
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_mb_pkg::*;
#(
  parameter int                            NUM_BANKS   = 2,
  parameter logic [NUM_BANKS*WIDTH_FIELD-1:0] BANK_WIDTHS = {NUM_BANKS{6'd32}},
  parameter int                            ADDR_W      = 8,
  localparam int                           PADS        = NUM_BANKS * BANK_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PADS-1:0]   pad_in,
  output logic [PADS-1:0]   pad_out,
  output logic [PADS-1:0]   pad_oe,
  output logic              irq
);
  localparam int BSEL_W = ADDR_W - 5;

  logic [BSEL_W-1:0] bank_sel;
  logic [2:0]        word_idx;
  logic              unused_addr;

  assign bank_sel    = bus_addr[ADDR_W-1:5];
  assign word_idx    = bus_addr[4:2];
  assign unused_addr = ^bus_addr[1:0];

  logic [31:0]         rd_b  [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_b;
  logic [PADS-1:0]     stat_vec, mask_vec, dir_vec, od_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic we;
    assign we = bus_wr && (bank_sel == BSEL_W'(b));

    gpio_mb_bank #(
      .WIDTH(int'(BANK_WIDTHS[b*WIDTH_FIELD +: WIDTH_FIELD]))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (we),
      .idx    (word_idx),
      .wdata  (bus_wdata),
      .rdata  (rd_b[b]),
      .pad_in (pad_in[b*BANK_PINS +: BANK_PINS]),
      .pad_out(pad_out[b*BANK_PINS +: BANK_PINS]),
      .pad_oe (pad_oe[b*BANK_PINS +: BANK_PINS]),
      .irq    (irq_b[b]),
      .stat_o (stat_vec[b*BANK_PINS +: BANK_PINS]),
      .mask_o (mask_vec[b*BANK_PINS +: BANK_PINS]),
      .dir_o  (dir_vec[b*BANK_PINS +: BANK_PINS]),
      .od_o   (od_vec[b*BANK_PINS +: BANK_PINS])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) bus_rdata = rd_b[b];
    end
  end

  assign irq = |irq_b;
endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk
  import gpio_mb_pkg::*;
#(
  parameter int                            NUM_BANKS   = 2,
  parameter logic [NUM_BANKS*WIDTH_FIELD-1:0] BANK_WIDTHS = {NUM_BANKS{6'd32}},
  localparam int                           PADS        = NUM_BANKS * BANK_PINS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            irq,
  input logic [PADS-1:0] pad_out,
  input logic [PADS-1:0] pad_oe,
  input logic [PADS-1:0] stat_vec,
  input logic [PADS-1:0] mask_vec,
  input logic [PADS-1:0] dir_vec,
  input logic [PADS-1:0] od_vec
);
  function automatic logic [PADS-1:0] all_valid();
    logic [PADS-1:0] v;
    v = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      v[b*BANK_PINS +: BANK_PINS] = width_mask(int'(BANK_WIDTHS[b*WIDTH_FIELD +: WIDTH_FIELD]));
    return v;
  endfunction

  localparam logic [PADS-1:0] VALID = all_valid();

  assert_oe_only_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_vec) == '0);

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_vec) == '0);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(stat_vec) & ~stat_vec) == '0));

  assert_irq_quiet_when_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '0) |-> !irq);

  assert_no_bits_past_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_vec | mask_vec | od_vec) & ~VALID) == '0);
endmodule

bind gpio_multibank gpio_multibank_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .BANK_WIDTHS(BANK_WIDTHS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .irq     (irq),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .stat_vec(stat_vec),
  .mask_vec(mask_vec),
  .dir_vec (dir_vec),
  .od_vec  (od_vec)
);

// File: tb/gpio_multibank_test.sv
module gpio_multibank_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB   = 3;
  localparam int AW   = 8;
  localparam int PADS = NB * 32;
  localparam logic [NB*6-1:0] WIDTHS = {6'd32, 6'd0, 6'd8};

  localparam int K_RD  = 0;
  localparam int K_IRQ = 1;
  localparam int K_OE  = 2;
  localparam int K_OUT = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [PADS-1:0] pad_in;
  logic [PADS-1:0] pad_out;
  logic [PADS-1:0] pad_oe;
  logic            irq;

  gpio_multibank #(
    .NUM_BANKS  (NB),
    .BANK_WIDTHS(WIDTHS),
    .ADDR_W     (AW)
  ) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Monitor: pops expected items and compares shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_IRQ:   act = {31'd0, irq};
          K_OE:    act = pad_oe[31:0];
          default: act = pad_out[31:0];
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [AW-1:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    if (kind == K_RD) bus_addr = a;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic set_pad(input int bank, input logic [31:0] v);
    @(negedge clk);
    pad_in[bank*32 +: 32] = v;
    repeat (4) @(posedge clk);
  endtask

  // Watchdog
  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    pad_in    = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_item(K_RD,  8'h08, 32'h0000_00FF, "R1 bank0 dir");
    expect_item(K_RD,  8'h48, 32'hFFFF_FFFF, "R1 bank2 dir");
    expect_item(K_RD,  8'h5C, 32'h0,         "R1 bank2 status");
    expect_item(K_IRQ, 8'h00, 32'h0,         "R1 irq");
    expect_item(K_OE,  8'h00, 32'h0,         "R1 pad_oe");

    // R2 write/readback
    wr(8'h4C, 32'hA5A5_0F0F);
    expect_item(K_RD, 8'h4C, 32'hA5A5_0F0F, "R2 bank2 polarity");
    wr(8'h54, 32'h1234_5678);
    expect_item(K_RD, 8'h54, 32'h1234_5678, "R2 bank2 mask");
    wr(8'h4C, 32'h0);
    wr(8'h54, 32'h0);

    // R10 width clipping and empty bank
    wr(8'h14, 32'hFFFF_FFFF);
    expect_item(K_RD, 8'h14, 32'h0000_00FF, "R10 bank0 mask clipped");
    wr(8'h14, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    expect_item(K_RD, 8'h24, 32'h0, "R10 empty bank data");

    // R11 past the last bank
    wr(8'h64, 32'hFFFF_FFFF);
    expect_item(K_RD, 8'h64, 32'h0, "R11 out-of-range read");

    // R3 direction and data read
    wr(8'h08, 32'h0000_00F0);
    wr(8'h04, 32'h0000_000A);
    expect_item(K_OE,  8'h00, 32'h0000_000F, "R3 pad_oe");
    expect_item(K_OUT, 8'h00, 32'h0000_000A, "R3 pad_out");
    set_pad(0, 32'h0000_0050);
    expect_item(K_RD, 8'h04, 32'h0000_005A, "R3 mixed data read");

    // R4 open drain
    wr(8'h00, 32'h0000_0003);
    expect_item(K_OUT, 8'h00, 32'h0000_0008, "R4 pad_out");
    expect_item(K_OE,  8'h00, 32'h0000_000D, "R4 pad_oe");

    // R5 / R6 edge modes on bank 2: pin0 rising, pin1 falling, pin2 both
    wr(8'h4C, 32'h0000_0001);
    wr(8'h50, 32'h0000_0004);
    set_pad(2, 32'h0000_0007);
    expect_item(K_RD,  8'h5C, 32'h0000_0005, "R5 R6 rising edges");
    expect_item(K_IRQ, 8'h00, 32'h0,         "R9 masked pending");
    set_pad(2, 32'h0000_0000);
    expect_item(K_RD, 8'h5C, 32'h0000_0007, "R5 R6 falling edges");

    // R9 unmask exposes pending, R8 clear semantics
    wr(8'h54, 32'h0000_0002);
    expect_item(K_IRQ, 8'h00, 32'h1, "R9 unmask raises irq");
    wr(8'h5C, 32'h0);
    expect_item(K_RD, 8'h5C, 32'h0000_0007, "R8 write zero keeps");
    wr(8'h5C, 32'h0000_0002);
    expect_item(K_RD,  8'h5C, 32'h0000_0005, "R8 write one clears");
    expect_item(K_IRQ, 8'h00, 32'h0,         "R9 irq drops");

    // R7 level modes: pin4 high level, pin5 low level
    wr(8'h4C, 32'h0000_0011);
    wr(8'h58, 32'h0000_0030);
    repeat (2) @(posedge clk);
    expect_item(K_RD, 8'h5C, 32'h0000_0025, "R7 low level");
    set_pad(2, 32'h0000_0010);
    expect_item(K_RD, 8'h5C, 32'h0000_0035, "R7 high level");
    wr(8'h5C, 32'h0000_0030);
    expect_item(K_RD, 8'h5C, 32'h0000_0035, "R7 clear while level held");
    set_pad(2, 32'h0000_0030);
    wr(8'h5C, 32'h0000_0020);
    expect_item(K_RD, 8'h5C, 32'h0000_0015, "R7 clear after level gone");

    // R10 events past width ignored; R9 shared line across banks
    wr(8'h54, 32'h0);
    set_pad(0, 32'hFFFF_FF50);
    set_pad(0, 32'h0000_0000);
    expect_item(K_RD,  8'h1C, 32'h0000_0050, "R10 status clipped");
    expect_item(K_IRQ, 8'h00, 32'h0,         "R9 all masks clear");
    wr(8'h14, 32'h0000_0040);
    expect_item(K_IRQ, 8'h00, 32'h1, "R9 other bank drives irq");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule